// File: doc/BRIEF.md
# Run-Length Expander

This block turns a compressed stream of run-length pairs back into the plain sample stream. Words arrive on one valid/ready input. Each word carries a tag bit that marks it as a repeat count or as a sample value. A pair always sends its count word first and its value word second. The block keeps the count in a register and waits for the value. It then emits that value on a valid/ready output as many times as the count says. A stream built from runs of identical samples is therefore rebuilt sample for sample.

A small phase tracker decides what each incoming word means. If a word's tag does not fit the expected phase, a sticky error flag is set. The tracker then falls back into step on a count-tagged word. While a run is being emitted, the input is held off. The output word stays frozen whenever the consumer stalls. A pair whose count is zero emits nothing, which absorbs the empty leading pair that some encoders produce. A last marker sent with a value word is placed only on the final copy of that value.

Top module: `rle_expander`

## Requirements
- R1: After synchronous reset, out_valid is 0, in_ready is 1 and sync_err is 0, and the tracker expects a count word.
- R2: A count word (in_is_count=1) with value n, followed by a value word (in_is_count=0) holding v, produces exactly n output beats carrying v. Pairs are emitted in arrival order.
- R3: A pair whose count is 0 produces no output beat.
- R4: in_ready is 0 during every cycle in which out_valid is 1. No input word is taken while a run is being emitted.
- R5: While out_valid is 1 and out_ready is 0, the next cycle still has out_valid at 1, with out_data and out_last unchanged.
- R6: out_last is 1 only on the final beat of a run whose value word had in_last=1. Every other beat carries out_last=0.
- R7: A value-tagged word that arrives when a count is expected sets sync_err and is dropped. It produces no output.
- R8: A count-tagged word that arrives when a value is expected sets sync_err. That word replaces the held count, and the tracker keeps expecting a value.
- R9: Once set, sync_err stays at 1 until reset, whatever traffic follows.
- R10: The largest count, 2^CNT_W-1, produces exactly that many beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| in_word | input | WORD_W | Count (low CNT_W bits) or value (low DATA_W bits) |
| in_is_count | input | 1 | Tag: 1 marks a count word, 0 marks a value word |
| in_last | input | 1 | End-of-stream marker on a value word |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat when high |
| out_data | output | DATA_W | Repeated value |
| out_last | output | 1 | Final beat of the stream |
| sync_err | output | 1 | Sticky tag/phase mismatch flag |

## Verification
The first stream has the shape an encoder produces: an empty leading pair, runs of several lengths including single samples, and a last marker on the final pair. It is replayed with the consumer always ready, ready at random, and ready every other cycle. These three runs separate a wrong repeat count from a failure to hold data under stall. A zero count placed in mid-stream and a run of the maximum count test the edges of the repeat counter. Two malformed sequences test the error path, one with a stray value word and one with a doubled count word. Each shows whether the offending word is dropped or adopted, and each is followed by clean traffic to confirm that the flag stays set.

// File: rtl/rle_pkg.sv
package rle_pkg;

    typedef enum logic {
        PH_COUNT = 1'b0,
        PH_VALUE = 1'b1
    } phase_e;

    // A word matches the phase when its tag agrees with what is expected.
    function automatic logic tag_matches(phase_e ph, logic is_count);
        return (ph == PH_COUNT) ? is_count : !is_count;
    endfunction

endpackage

// File: rtl/rle_pair_split.sv
module rle_pair_split
    import rle_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    localparam int WORD_W = (DATA_W > CNT_W) ? DATA_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [WORD_W-1:0] word,
    input  logic              is_count,
    input  logic              last,
    output phase_e            phase,
    output logic              load,
    output logic [CNT_W-1:0]  load_cnt,
    output logic [DATA_W-1:0] load_val,
    output logic              load_last,
    output logic              err
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_COUNT;
            cnt_q <= '0;
            err   <= 1'b0;
        end else if (accept) begin
            if (!tag_matches(phase, is_count)) begin
                err <= 1'b1;
            end
            if (is_count) begin
                // Count words always refill the held count (resync path too).
                cnt_q <= word[CNT_W-1:0];
                phase <= PH_VALUE;
            end else if (phase == PH_VALUE) begin
                phase <= PH_COUNT;
            end
        end
    end

    always_comb begin
        load      = accept && (phase == PH_VALUE) && !is_count;
        load_cnt  = cnt_q;
        load_val  = word[DATA_W-1:0];
        load_last = last;
    end

endmodule

// File: rtl/rle_repeat_engine.sv
module rle_repeat_engine #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic [DATA_W-1:0] load_val,
    input  logic              load_last,
    input  logic              out_ready,
    output logic              busy,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);

    typedef struct packed {
        logic [CNT_W-1:0]  rem;
        logic [DATA_W-1:0] val;
        logic              lst;
    } run_t;

    run_t run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            run_q <= '0;
        end else if (load && (load_cnt != '0)) begin
            busy      <= 1'b1;
            run_q.rem <= load_cnt;
            run_q.val <= load_val;
            run_q.lst <= load_last;
        end else if (busy && out_ready) begin
            if (run_q.rem == CNT_W'(1)) begin
                busy <= 1'b0;
            end
            run_q.rem <= run_q.rem - 1'b1;
        end
    end

    always_comb begin
        out_data = run_q.val;
        out_last = busy && run_q.lst && (run_q.rem == CNT_W'(1));
    end

endmodule

// File: rtl/rle_expander.sv
module rle_expander
    import rle_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    localparam int WORD_W = (DATA_W > CNT_W) ? DATA_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_is_count,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              sync_err
);

    phase_e            phase;
    logic              accept;
    logic              load;
    logic [CNT_W-1:0]  load_cnt;
    logic [DATA_W-1:0] load_val;
    logic              load_last;
    logic              busy;

    assign in_ready  = !busy;
    assign accept    = in_valid && in_ready;
    assign out_valid = busy;

    rle_pair_split #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_split (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .word      (in_word),
        .is_count  (in_is_count),
        .last      (in_last),
        .phase     (phase),
        .load      (load),
        .load_cnt  (load_cnt),
        .load_val  (load_val),
        .load_last (load_last),
        .err       (sync_err)
    );

    rle_repeat_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rep (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_cnt  (load_cnt),
        .load_val  (load_val),
        .load_last (load_last),
        .out_ready (out_ready),
        .busy      (busy),
        .out_data  (out_data),
        .out_last  (out_last)
    );

endmodule

// File: rtl/rle_expander_chk.sv
module rle_expander_chk
    import rle_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_is_count,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic              sync_err,
    input phase_e            phase
);

    // R4
    a_r4_no_accept_while_busy: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R5
    a_r5_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R6
    a_r6_last_ends_run: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R7
    a_r7_stray_value_flags: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_is_count && phase == PH_COUNT) |=> (sync_err && !out_valid));

    // R8
    a_r8_double_count_flags: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_is_count && phase == PH_VALUE) |=> (sync_err && phase == PH_VALUE));

    // R9
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> sync_err);

endmodule

bind rle_expander rle_expander_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_is_count (in_is_count),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_last    (out_last),
    .sync_err    (sync_err),
    .phase       (phase)
);

// File: tb/rle_expander_tb_top.sv
`timescale 1ns/1ps
module rle_expander_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_word = '0;
    logic       in_is_count = 1'b0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_last;
    logic       sync_err;

    always #2.5 clk = ~clk;

    rle_expander dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_is_count(in_is_count), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .sync_err(sync_err)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Behavioural model state
    logic [8:0] exp_q[$];      // {last, data}
    bit         m_want_value = 1'b0;
    int         m_cnt = 0;
    bit         m_err = 1'b0;

    int          rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = lfsr[0];
            default: out_ready = ~out_ready;
        endcase
    end

    // Per-clock comparison against the model
    bit         pv = 1'b0, pr = 1'b0, pl = 1'b0;
    logic [7:0] pd = '0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                chk(!in_ready, "R4", int'(in_ready), 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3/R7 unexpected beat", int'(out_data), -1);
                end else begin
                    chk(out_data == exp_q[0][7:0], "R2", int'(out_data), int'(exp_q[0][7:0]));
                    chk(out_last == exp_q[0][8], "R6", int'(out_last), int'(exp_q[0][8]));
                    if (out_ready) void'(exp_q.pop_front());
                end
            end
            if (pv && !pr)
                chk(out_valid && out_data == pd && out_last == pl, "R5",
                    int'(out_data), int'(pd));
            pv = out_valid; pr = out_ready; pd = out_data; pl = out_last;
        end else begin
            pv = 1'b0;
        end
    end

    task automatic model_word(input int w, input bit is_cnt, input bit lst);
        if (!m_want_value) begin
            if (is_cnt) begin m_cnt = w; m_want_value = 1'b1; end
            else m_err = 1'b1;
        end else begin
            if (is_cnt) begin m_err = 1'b1; m_cnt = w; end
            else begin
                for (int i = 0; i < m_cnt; i++)
                    exp_q.push_back({lst && (i == m_cnt - 1), 8'(w)});
                m_want_value = 1'b0;
            end
        end
    endtask

    task automatic send(input int w, input bit is_cnt, input bit lst);
        model_word(w, is_cnt, lst);
        in_valid = 1'b1; in_word = 8'(w); in_is_count = is_cnt; in_last = lst;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic pair(input int n, input int v, input bit lst);
        send(n, 1'b1, 1'b0);
        send(v, 1'b0, lst);
    endtask

    task automatic drain(input string req);
        int t = 0;
        while ((exp_q.size() != 0 || out_valid) && t < 3000) begin
            @(negedge clk); t++;
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_q.delete(); m_want_value = 1'b0; m_cnt = 0; m_err = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready, "R1 in_ready", int'(in_ready), 1);
        chk(!sync_err, "R1 sync_err", int'(sync_err), 0);
    endtask

    task automatic encoder_stream();
        pair(0, 0, 0);          // empty leading pair
        pair(3, 35, 0);
        pair(1, 42, 0);
        pair(4, 17, 0);
        pair(1, 55, 0);
        pair(2, 33, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2 R6: encoder-shaped stream with three consumer patterns
        for (int m = 0; m < 3; m++) begin
            rdy_mode = m;
            encoder_stream();
            drain("R2 stream");
        end
        chk(!sync_err, "R2 no error on clean stream", int'(sync_err), 0);

        // R3: zero count alone, then mid-stream
        rdy_mode = 0;
        pair(0, 99, 1);
        repeat (5) @(negedge clk);
        chk(!out_valid, "R3 zero pair", int'(out_valid), 0);
        rdy_mode = 1;
        pair(2, 7, 0); pair(0, 8, 0); pair(1, 9, 1);
        drain("R3 mid-stream");

        // R10: maximum count under alternating back-pressure
        rdy_mode = 2;
        pair(255, 200, 1);
        drain("R10 max count");

        // R7: stray value word dropped
        do_reset();
        rdy_mode = 0;
        send(77, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        chk(!out_valid, "R7 dropped", int'(out_valid), 0);
        chk(sync_err == m_err, "R7 flag", int'(sync_err), int'(m_err));
        pair(2, 5, 1);
        drain("R7 resync");

        // R8: doubled count word adopted
        do_reset();
        rdy_mode = 1;
        send(3, 1'b1, 1'b0);
        send(2, 1'b1, 1'b0);
        send(9, 1'b0, 1'b1);
        drain("R8 new count");
        chk(sync_err == m_err, "R8 flag", int'(sync_err), int'(m_err));

        // R9: flag stays through clean traffic
        encoder_stream();
        drain("R9 traffic");
        chk(sync_err, "R9 sticky", int'(sync_err), 1);
        do_reset();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule